// File: doc/BRIEF.md
# Bus-Attached Successive-Approximation Converter Controller

This block is the digital core of a four-input, eight-bit successive-approximation converter that sits on a microprocessor bus. A host selects an input arrangement and starts a conversion by writing. It then waits for the active-low interrupt and reads the eight-bit result over the same bidirectional data bus. The low data lines also carry the input-selection address during a write. The analog parts (comparator, DAC, input switches) sit outside the block. The controller drives the trial code towards the DAC, one-hot positive and negative input selects towards the switches, and reads back a single comparator bit.

The asynchronous chip-select, read and write strobes each pass through a two-flop synchronizer. Their edges are detected on the synchronized copies. A sequencer with four states runs the conversion: `ST_IDLE`, `ST_SET` (raise the trial bit), `ST_TEST` (sample the comparator and keep or drop the bit) and `ST_PAD` (wait out the fixed conversion time). The transitions are named as follows. *launch* goes from ST_IDLE to ST_SET on a start. *probe* goes from ST_SET to ST_TEST on every cycle. *next-bit* goes from ST_TEST back to ST_SET while bits remain. *last-bit* goes from ST_TEST to ST_PAD after bit 0. *finish* goes from ST_PAD to ST_IDLE on the final cycle and loads the result. *abort* goes from any state to ST_IDLE when a write strobe falls.

Top module: `sar_bus_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `dac_code` is 0, the bus is not driven, and the selection is address 0 (positive = input 0, negative = input 1).
- R2: The block drives `db` only while `cs_n` and `rd_n` are both 0, and it then shows the result latch. Otherwise an external driver on `db` is seen unchanged.
- R3: When the synchronized `wr_n` falls with `cs_n` low, `intr_n` goes to 1 and any running conversion is abandoned without producing a result.
- R4: When the synchronized `wr_n` rises with `cs_n` low and `rd_n` high, `db[4:0]` is latched as the address and a conversion starts. The result is loaded and `intr_n` falls exactly CONV_CYCLES (40) clocks after the start edge, and at no other time.
- R5: If `rd_n` is low when the write strobe rises, the address is kept, no conversion starts, `intr_n` stays high, and the previous result stays readable.
- R6: The start of a read (`cs_n` and `rd_n` both low after not both being low) drives `intr_n` to 1.
- R7: If address bit 2 = 0, the mode is differential and bits 3 and 4 are ignored. Bit 1 picks pair {0,1} or {2,3}. Bit 0 = 0 makes the even input positive, and bit 0 = 1 makes the odd input positive. The other input of the pair is negative.
- R8: If bit 2 = 1 and bit 3 = 0, the mode is single-ended. Bits 1:0 pick the positive input, and the negative is analog ground (`neg_gnd` = 1).
- R9: If bit 2 = 1 and bit 3 = 1, the mode is pseudo-differential. Bits 1:0 = 0..2 pick the positive input, and input 3 is negative. Code 3 is reserved: no positive input and negative at ground, so the result is 0.
- R10: The conversion tests bits from MSB to LSB. Each bit is set, the comparator (1 = input at or above `dac_code`) is sampled one clock later, and the bit is kept only on 1. The result equals the positive minus the negative input, or 0 when the positive input is lower.
- R11: If a conversion finishes in the same cycle as a read starts, the finish wins and `intr_n` goes low.
- R12: Each strobe takes effect on the second clock edge after it is first captured, so an action lands three edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| db | inout | 8 | Data bus; bits 4:0 carry the address on writes |
| intr_n | output | 1 | Result-ready interrupt, active low |
| pos_sel | output | 4 | One-hot positive input select |
| neg_sel | output | 4 | One-hot negative input select |
| neg_gnd | output | 1 | Negative side tied to analog ground |
| dac_code | output | 8 | Trial code for the DAC |
| cmp_in | input | 1 | Comparator: 1 when input is at or above dac_code |

## Verification
The end of a conversion and the start of a host read can fall on the same clock edge. One loads the result and pulls the interrupt low; the other returns it high. The bench provokes the collision by lowering the read strobe exactly 40 clocks after raising the write strobe. At that point the three-edge synchronizer delay lands the read on the finish edge. A correct design shows the interrupt low afterwards with the new result on the bus, and a later separate read still clears it.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SET,
        ST_TEST,
        ST_PAD
    } sar_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    logic [W-1:0] meta_q;

    // strobes are inactive-high: reset to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '1;
            lvl      <= '1;
            lvl_prev <= '1;
        end else begin
            meta_q   <= pin_n;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end
endmodule

// File: rtl/mux_decode.sv
module mux_decode #(
    parameter int NCH = 4,
    parameter int AW  = 5
) (
    input  logic [AW-1:0]  addr,
    output logic [NCH-1:0] pos_sel,
    output logic [NCH-1:0] neg_sel,
    output logic           neg_gnd
);
    localparam int SW = $clog2(NCH);

    logic [SW-1:0] idx;
    logic          unused_hi;

    assign idx       = addr[SW-1:0];
    assign unused_hi = addr[AW-1];

    always_comb begin
        pos_sel = '0;
        neg_sel = '0;
        neg_gnd = 1'b0;
        if (!addr[SW]) begin
            // differential: partner is idx with bit 0 flipped
            pos_sel[idx]           = 1'b1;
            neg_sel[idx ^ SW'(1)]  = 1'b1;
        end else if (!addr[SW+1]) begin
            pos_sel[idx] = 1'b1;
            neg_gnd      = 1'b1;
        end else if (idx == SW'(NCH-1)) begin
            neg_gnd = 1'b1;           // reserved code: nothing positive
        end else begin
            pos_sel[idx]     = 1'b1;
            neg_sel[NCH-1]   = 1'b1;
        end
    end
endmodule

// File: rtl/sar_engine.sv
module sar_engine
    import sarc_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CONV_CYCLES = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic          cmp_in,
    output logic [DW-1:0] trial,
    output logic [DW-1:0] result,
    output logic          finish
);
    localparam int BW = $clog2(DW);
    localparam int CW = $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    sar_state_e    state_q, state_d;
    logic [BW-1:0] bit_q;
    logic [CW-1:0] cyc_q;
    logic [DW-1:0] sar_q, res_q, lo_mask;

    assign finish  = (state_q == ST_PAD) && (cyc_q == LAST) && !abort;
    assign trial   = sar_q;
    assign result  = res_q;
    assign lo_mask = (DW'(1) << bit_q) - DW'(1);

    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = ST_IDLE;
        end else if (start) begin
            state_d = ST_SET;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SET:  state_d = ST_TEST;
                ST_TEST: state_d = (bit_q == '0) ? ST_PAD : ST_SET;
                ST_PAD:  state_d = (cyc_q == LAST) ? ST_IDLE : ST_PAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q <= '0;
            res_q <= '0;
            bit_q <= '0;
            cyc_q <= '0;
        end else if (start && !abort) begin
            sar_q <= '0;
            bit_q <= BW'(DW - 1);
            cyc_q <= '0;
        end else begin
            if (state_q != ST_IDLE) cyc_q <= cyc_q + CW'(1);
            unique case (state_q)
                ST_IDLE: ;
                ST_SET:  sar_q[bit_q] <= 1'b1;
                ST_TEST: begin
                    if (!cmp_in) sar_q[bit_q] <= 1'b0;
                    if (bit_q != '0) bit_q <= bit_q - BW'(1);
                end
                ST_PAD:  if (finish) res_q <= sar_q;
            endcase
        end
    end

    // bits below the one under trial are still clear when it is raised
    assert_low_bits_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SET) |-> ((sar_q & lo_mask) == '0));

    // the result latch only moves on a finish
    assert_result_on_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(res_q));
endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int CONV_CYCLES = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    inout  wire  [DW-1:0]  db,
    output logic           intr_n,
    output logic [NCH-1:0] pos_sel,
    output logic [NCH-1:0] neg_sel,
    output logic           neg_gnd,
    output logic [DW-1:0]  dac_code,
    input  logic           cmp_in
);
    localparam int SW = $clog2(NCH);
    localparam int AW = SW + 3;

    logic [2:0]    lvl, lvl_prev;
    logic          cs_s, rd_s, wr_s;
    logic          wr_fall_act, wr_rise_act, read_start, start, retain;
    logic          finish;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] result;
    logic          unused_db;

    strobe_sync #(.W(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    ({cs_n, rd_n, wr_n}),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    assign cs_s        = lvl[2];
    assign rd_s        = lvl[1];
    assign wr_s        = lvl[0];
    assign wr_fall_act = !wr_s && lvl_prev[0] && !cs_s;
    assign wr_rise_act = wr_s && !lvl_prev[0] && !cs_s;
    assign start       = wr_rise_act && rd_s;
    assign retain      = wr_rise_act && !rd_s;
    assign read_start  = !cs_s && !rd_s && !(!lvl_prev[2] && !lvl_prev[1]);
    assign unused_db   = ^db[DW-1:AW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr_q <= '0;
        else if (start) addr_q <= db[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          intr_n <= 1'b1;
        else if (finish)                     intr_n <= 1'b0;
        else if (wr_fall_act || read_start)  intr_n <= 1'b1;
    end

    mux_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr    (addr_q),
        .pos_sel (pos_sel),
        .neg_sel (neg_sel),
        .neg_gnd (neg_gnd)
    );

    sar_engine #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .abort  (wr_fall_act),
        .cmp_in (cmp_in),
        .trial  (dac_code),
        .result (result),
        .finish (finish)
    );

    assign db = (!cs_n && !rd_n) ? result : 'z;

    assert_wr_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fall_act |=> intr_n);
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (read_start && !finish) |=> intr_n);
    assert_finish_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !intr_n);
    assert_intr_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n) |-> $past(finish));
    assert_retain_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        retain |=> $stable(addr_q));
    assert_pos_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pos_sel));
    assert_neg_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({neg_sel, neg_gnd}) == 1);
    assert_sides_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_sel & neg_sel) == '0);
endmodule

// File: tb/tb_sar_bus_ctrl.sv
module tb_sar_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] tb_db = '0;
    logic       tb_oe = 1'b0;
    wire  [7:0] db;
    logic       intr_n, neg_gnd, cmp_in;
    logic [3:0] pos_sel, neg_sel;
    logic [7:0] dac_code;
    logic [7:0] ain [4];
    int         n_vec = 0, n_bad = 0;
    bit         done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign db = tb_oe ? tb_db : 8'bz;

    sar_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .db(db), .intr_n(intr_n), .pos_sel(pos_sel), .neg_sel(neg_sel),
        .neg_gnd(neg_gnd), .dac_code(dac_code), .cmp_in(cmp_in)
    );

    // comparator model: difference of sampled codes against the trial code
    always_comb begin
        int pv, nv;
        pv = 0;
        nv = 0;
        for (int i = 0; i < 4; i++) begin
            if (pos_sel[i]) pv = int'(ain[i]);
            if (neg_sel[i]) nv = int'(ain[i]);
        end
        cmp_in = ((pv > nv) ? (pv - nv) : 0) >= int'(dac_code);
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int expect_res(input logic [3:0] p, input logic [3:0] n);
        int pv, nv;
        pv = 0;
        nv = 0;
        for (int i = 0; i < 4; i++) begin
            if (p[i]) pv = int'(ain[i]);
            if (n[i]) nv = int'(ain[i]);
        end
        return (pv > nv) ? pv - nv : 0;
    endfunction

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // ends on the negedge where wr_n has just been raised
    task automatic wr_pulse(input logic [4:0] a);
        @(negedge clk);
        tb_db = {3'b000, a};
        tb_oe = 1'b1;
        cs_n  = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 intr", int'(intr_n), 1);
        chk("R1 dac", int'(dac_code), 0);
        chk("R1 sel", int'({pos_sel, neg_sel, neg_gnd}), int'({4'b0001, 4'b0010, 1'b0}));
        tb_db = 8'hA5;
        tb_oe = 1'b1;
        #1 chk("R1 bus idle", int'(db), 8'hA5);
    endtask

    task automatic t_bus_float;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b0; tb_db = 8'h3C; tb_oe = 1'b1;
        #1 chk("R2 cs high", int'(db), 8'h3C);
        @(negedge clk);
        tb_oe = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; tb_db = 8'hC3; tb_oe = 1'b1;
        #1 chk("R2 rd high", int'(db), 8'hC3);
        @(negedge clk);
        tb_oe = 1'b0; rd_n = 1'b0;
        #1 chk("R2 read", int'(db), 0);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_conv(input logic [4:0] a, input logic [3:0] ep, input logic [3:0] en,
                          input logic eg, input string req);
        int er;
        er = expect_res(ep, en);
        wr_pulse(a);
        repeat (4) @(negedge clk);
        tb_oe = 1'b0;
        chk({req, " sel"}, int'({pos_sel, neg_sel, neg_gnd}), int'({ep, en, eg}));
        repeat (38) @(negedge clk);
        chk("R4 not yet", int'(intr_n), 1);
        @(negedge clk);
        chk("R4 done", int'(intr_n), 0);
        rd_n = 1'b0;
        #1 chk({req, " R10 result"}, int'(db), er);
        repeat (2) @(negedge clk);
        chk("R12 latency", int'(intr_n), 0);
        @(negedge clk);
        chk("R6 read clear", int'(intr_n), 1);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_retain;
        logic [8:0] sel0;
        sel0 = {pos_sel, neg_sel, neg_gnd};
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        #1 chk("R5 old data", int'(db), 170);
        repeat (4) @(negedge clk);
        rd_n = 1'b1;
        chk("R5 sel kept", int'({pos_sel, neg_sel, neg_gnd}), int'(sel0));
        repeat (45) @(negedge clk);
        chk("R5 no start", int'(intr_n), 1);
        rd_n = 1'b0;
        #1 chk("R5 result kept", int'(db), 170);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_abort;
        // unread result first, so the write falling edge has something to clear
        wr_pulse(5'b00110);
        repeat (4) @(negedge clk);
        tb_oe = 1'b0;
        repeat (40) @(negedge clk);
        chk("R4 pending", int'(intr_n), 0);
        wr_pulse(5'b00100);
        // wr_pulse lowered wr_n 4 negedges before returning: cleared by now
        chk("R3 wr clear", int'(intr_n), 1);
        repeat (20) @(negedge clk);
        tb_db = 8'h05;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        tb_oe = 1'b0;
        chk("R3 new sel", int'(pos_sel), 4'b0010);
        repeat (38) @(negedge clk);
        chk("R3 aborted", int'(intr_n), 1);
        @(negedge clk);
        chk("R3 restart done", int'(intr_n), 0);
        rd_n = 1'b0;
        #1 chk("R3 restart result", int'(db), int'(ain[1]));
        repeat (3) @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_collision;
        wr_pulse(5'b01110);   // pseudo-differential, input 2 against input 3
        repeat (4) @(negedge clk);
        tb_oe = 1'b0;
        repeat (36) @(negedge clk);
        rd_n = 1'b0;          // read lands on the finish edge
        repeat (3) @(negedge clk);
        chk("R11 finish wins", int'(intr_n), 0);
        chk("R11 data", int'(db), expect_res(4'b0100, 4'b1000));
        rd_n = 1'b1;
        repeat (3) @(negedge clk);
        rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 later read", int'(intr_n), 1);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        ain[0] = 8'd30; ain[1] = 8'd200; ain[2] = 8'd150; ain[3] = 8'd17;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        tb_oe = 1'b0;
        t_bus_float();
        t_conv(5'b00000, 4'b0001, 4'b0010, 1'b0, "R7 pair0");
        t_conv(5'b00001, 4'b0010, 4'b0001, 1'b0, "R7 pair0 swap");
        t_conv(5'b00010, 4'b0100, 4'b1000, 1'b0, "R7 pair1");
        t_conv(5'b00011, 4'b1000, 4'b0100, 1'b0, "R7 pair1 swap");
        t_conv(5'b11001, 4'b0010, 4'b0001, 1'b0, "R7 high bits ignored");
        t_retain();
        ain[3] = 8'd255;
        t_conv(5'b00100, 4'b0001, 4'b0000, 1'b1, "R8 in0");
        t_conv(5'b00101, 4'b0010, 4'b0000, 1'b1, "R8 in1");
        t_conv(5'b00111, 4'b1000, 4'b0000, 1'b1, "R8 full scale");
        ain[3] = 8'd17;
        t_conv(5'b01100, 4'b0001, 4'b1000, 1'b0, "R9 in0");
        t_conv(5'b01101, 4'b0010, 4'b1000, 1'b0, "R9 in1");
        t_conv(5'b01110, 4'b0100, 4'b1000, 1'b0, "R9 in2");
        t_conv(5'b01111, 4'b0000, 4'b0000, 1'b1, "R9 reserved");
        t_abort();
        t_collision();
        done_flag = 1'b1;
        finish_run();
    end
endmodule